// File: doc/BRIEF.md
# Time-Encoded Edge-Triggered Flip-Flop

This block models a rising-edge D flip-flop whose waveforms are not ordinary wires but per-cycle bundles measured against a fixed reference clock. Each reference cycle is split into 2^OFS_W equal slots. A bundle gives a signal's level at the start of the cycle and a set of transition slots, each with a valid bit and an offset. An offset k marks the instant k/2^OFS_W of a reference period after the cycle start. The flip-flop finds the rising transition of its encoded clock and captures the encoded data level at that instant. It reports the result as an output bundle in the same reference cycle.

The output's level at the start of a cycle comes from a register on the reference clock. That register holds the output level at the end of the previous cycle. It is the only storage in the block, and it breaks the feedback path of the held value at the cycle boundary. All other logic is combinational. An encoded clock may carry at most two transitions per cycle. Any transition beyond the second is dropped and flagged.

Top module: `tde_dff`

## Requirements
- R1: The output bundle and the overflow flag for a reference cycle are valid in that same cycle. They depend only on that cycle's input bundles and the stored level.
- R2: At a rising clock transition at offset t, the captured value is the data start level XOR the parity of the valid data transitions with offset strictly below t. A data transition at offset t itself is late and is not seen.
- R3: If the captured value differs from q_start, then q_vld is 1 and q_ofs equals t, zero-extended to OUT_OFS_W bits. Otherwise q_vld is 0 and q_ofs is 0.
- R4: q_start equals the output level at the end of the previous cycle. With no rising clock transition, the level is held.
- R5: Clock transitions are taken in slot order (slot i at ck_ofs[i*OFS_W +: OFS_W]), and slots whose valid bit is 0 are ignored. The r-th counted transition (r from 0) leaves the clock at level ck_start XOR (r even). It is rising when that level is 1. Offsets of valid clock slots are strictly increasing.
- R6: When more than two clock valid bits are set, ck_overflow is 1 in that cycle and every valid transition after the second is ignored. Otherwise ck_overflow is 0.
- R7: While rst is high, q_start and q_vld are 0, and the stored level becomes 0 at that edge.
- R8: Over random encoded stimulus, the output bundles match an ordinary rising-edge D flip-flop simulated slot by slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ck_start | input | 1 | Encoded clock level at cycle start |
| ck_vld | input | CK_SLOTS | Valid bit per clock transition slot |
| ck_ofs | input | CK_SLOTS*OFS_W | Offset per clock transition slot |
| d_start | input | 1 | Encoded data level at cycle start |
| d_vld | input | D_SLOTS | Valid bit per data transition slot |
| d_ofs | input | D_SLOTS*OFS_W | Offset per data transition slot |
| q_start | output | 1 | Output level at cycle start |
| q_vld | output | 1 | Output transition present this cycle |
| q_ofs | output | OUT_OFS_W | Offset of the output transition |
| ck_overflow | output | 1 | More than two clock transitions were offered |

## Verification
Every output transition and the overflow flag are due in the same reference cycle as the input bundle that causes them. The bench therefore applies each bundle one nanosecond after a rising reference edge and compares at the falling edge of that same cycle. The effect through the loop register shows up one cycle later, as q_start of the next bundle. The scoreboard predicts it by carrying its own model level from item to item. Reset cycles are predicted as quiet, and the predicted level is cleared to zero.

// File: rtl/tde_pkg.sv
package tde_pkg;

  // Limit on encoded clock transitions honoured per reference cycle
  localparam int unsigned TDE_MAX_CK_EDGES = 2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2
  } edge_kind_e;

endpackage

// File: rtl/tde_clk_decode.sv
module tde_clk_decode
  import tde_pkg::*;
#(
  parameter int OFS_W = 4,
  parameter int SLOTS = 4
) (
  input  logic                   ck_start,
  input  logic [SLOTS-1:0]       ck_vld,
  input  logic [SLOTS*OFS_W-1:0] ck_ofs,
  output logic                   rise_hit,
  output logic [OFS_W-1:0]       rise_ofs,
  output logic                   overflow
);

  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0] rank [SLOTS];
  logic [CNT_W-1:0] total;
  edge_kind_e       kind [SLOTS];

  // Rank of each valid slot among the valid slots below it
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < SLOTS; i++) begin
      rank[i] = acc;
      acc     = acc + CNT_W'(ck_vld[i]);
    end
    total = acc;
  end

  // Classify each slot; ranks past the limit are dropped
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic lvl_after;
    assign lvl_after = ck_start ^ ~rank[g][0];
    always_comb begin
      if (!ck_vld[g] || (rank[g] >= CNT_W'(TDE_MAX_CK_EDGES)))
        kind[g] = EDGE_NONE;
      else if (lvl_after)
        kind[g] = EDGE_RISE;
      else
        kind[g] = EDGE_FALL;
    end
  end

  // Two alternating transitions hold at most one rising one
  always_comb begin
    rise_hit = 1'b0;
    rise_ofs = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (kind[i] == EDGE_RISE) begin
        rise_hit = 1'b1;
        rise_ofs = ck_ofs[i*OFS_W +: OFS_W];
      end
    end
  end

  assign overflow = (total > CNT_W'(TDE_MAX_CK_EDGES));

endmodule

// File: rtl/tde_data_sample.sv
module tde_data_sample #(
  parameter int OFS_W = 4,
  parameter int SLOTS = 4
) (
  input  logic                   d_start,
  input  logic [SLOTS-1:0]       d_vld,
  input  logic [SLOTS*OFS_W-1:0] d_ofs,
  input  logic [OFS_W-1:0]       at_ofs,
  output logic                   lvl
);

  logic [SLOTS-1:0] early;

  // A transition at the sampling offset itself counts as late
  for (genvar g = 0; g < SLOTS; g++) begin : g_tr
    assign early[g] = d_vld[g] && (d_ofs[g*OFS_W +: OFS_W] < at_ofs);
  end

  assign lvl = d_start ^ (^early);

endmodule

// File: rtl/tde_loop_reg.sv
module tde_loop_reg (
  input  logic clk,
  input  logic rst,
  input  logic nxt,
  output logic cur
);

  // Cycle-boundary break of the held-value feedback path
  always_ff @(posedge clk) begin
    if (rst) cur <= 1'b0;
    else     cur <= nxt;
  end

endmodule

// File: rtl/tde_dff.sv
module tde_dff #(
  parameter int OFS_W     = 4,
  parameter int CK_SLOTS  = 4,
  parameter int D_SLOTS   = 4,
  parameter int OUT_OFS_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ck_start,
  input  logic [CK_SLOTS-1:0]       ck_vld,
  input  logic [CK_SLOTS*OFS_W-1:0] ck_ofs,
  input  logic                      d_start,
  input  logic [D_SLOTS-1:0]        d_vld,
  input  logic [D_SLOTS*OFS_W-1:0]  d_ofs,
  output logic                      q_start,
  output logic                      q_vld,
  output logic [OUT_OFS_W-1:0]      q_ofs,
  output logic                      ck_overflow
);

  logic             rise_hit;
  logic [OFS_W-1:0] rise_ofs;
  logic             cap_lvl;
  logic             held;
  logic             end_lvl;
  logic             change;

  tde_clk_decode #(.OFS_W(OFS_W), .SLOTS(CK_SLOTS)) i_ck (
    .ck_start (ck_start),
    .ck_vld   (ck_vld),
    .ck_ofs   (ck_ofs),
    .rise_hit (rise_hit),
    .rise_ofs (rise_ofs),
    .overflow (ck_overflow)
  );

  tde_data_sample #(.OFS_W(OFS_W), .SLOTS(D_SLOTS)) i_ds (
    .d_start (d_start),
    .d_vld   (d_vld),
    .d_ofs   (d_ofs),
    .at_ofs  (rise_ofs),
    .lvl     (cap_lvl)
  );

  tde_loop_reg i_loop (
    .clk (clk),
    .rst (rst),
    .nxt (end_lvl),
    .cur (held)
  );

  assign change  = !rst && rise_hit && (cap_lvl != held);
  assign end_lvl = rise_hit ? cap_lvl : held;
  assign q_start = rst ? 1'b0 : held;
  assign q_vld   = change;
  assign q_ofs   = change ? OUT_OFS_W'(rise_ofs) : '0;

endmodule

// File: rtl/tde_dff_chk.sv
module tde_dff_chk #(
  parameter int OFS_W     = 4,
  parameter int CK_SLOTS  = 4,
  parameter int D_SLOTS   = 4,
  parameter int OUT_OFS_W = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic [CK_SLOTS-1:0]       ck_vld,
  input logic                      q_start,
  input logic                      q_vld,
  input logic [OUT_OFS_W-1:0]      q_ofs,
  input logic                      ck_overflow
);

  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |-> (!q_vld && !q_start));

  a_r7_zero_after_reset: assert property (@(posedge clk)
    rst |=> !q_start);

  a_r4_start_continuity: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_start == $past(q_start ^ q_vld)));

  a_r3_edge_needs_clock: assert property (@(posedge clk) disable iff (rst)
    q_vld |-> (ck_vld != '0));

  a_r3_idle_ofs_zero: assert property (@(posedge clk) disable iff (rst)
    !q_vld |-> (q_ofs == '0));

  a_r6_overflow_count: assert property (@(posedge clk) disable iff (rst)
    ck_overflow |-> ($countones(ck_vld) > 2));

  a_r6_no_false_overflow: assert property (@(posedge clk) disable iff (rst)
    !ck_overflow |-> ($countones(ck_vld) <= 2));

endmodule

bind tde_dff tde_dff_chk #(
  .OFS_W(OFS_W), .CK_SLOTS(CK_SLOTS), .D_SLOTS(D_SLOTS), .OUT_OFS_W(OUT_OFS_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .ck_vld      (ck_vld),
  .q_start     (q_start),
  .q_vld       (q_vld),
  .q_ofs       (q_ofs),
  .ck_overflow (ck_overflow)
);

// File: tb/test_tde_dff.sv
module test_tde_dff;

  localparam int OFS_W = 4;
  localparam int CK    = 4;
  localparam int DS    = 4;
  localparam int OW    = 6;
  localparam int NS    = 1 << OFS_W;

  typedef struct {
    bit    st;
    bit    vld;
    int    ofs;
    bit    ovf;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ck_start = 1'b0;
  logic [CK-1:0]     ck_vld = '0;
  logic [CK*OFS_W-1:0] ck_ofs = '0;
  logic              d_start = 1'b0;
  logic [DS-1:0]     d_vld = '0;
  logic [DS*OFS_W-1:0] d_ofs = '0;
  logic              q_start;
  logic              q_vld;
  logic [OW-1:0]     q_ofs;
  logic              ck_overflow;

  int   checks = 0;
  int   errors = 0;
  bit   mq = 1'b0;
  bit   ended = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  tde_dff #(.OFS_W(OFS_W), .CK_SLOTS(CK), .D_SLOTS(DS), .OUT_OFS_W(OW)) i_tde_dff (
    .clk (clk), .rst (rst),
    .ck_start (ck_start), .ck_vld (ck_vld), .ck_ofs (ck_ofs),
    .d_start (d_start), .d_vld (d_vld), .d_ofs (d_ofs),
    .q_start (q_start), .q_vld (q_vld), .q_ofs (q_ofs),
    .ck_overflow (ck_overflow)
  );

  // Driver: apply one bundle per reference cycle and predict with a slot-stepping model
  task automatic drive(input bit r, input bit cs, input bit [CK-1:0] cv, input int co[CK],
                       input bit ds, input bit [DS-1:0] dv, input int dof[DS], input string tag);
    exp_t e;
    bit   use_e[CK];
    int   k;
    int   nv;
    bit   q;
    bit   clv;
    bit   dl;
    @(posedge clk);
    #1;
    rst = r; ck_start = cs; ck_vld = cv; d_start = ds; d_vld = dv;
    for (int i = 0; i < CK; i++) ck_ofs[i*OFS_W +: OFS_W] = OFS_W'(co[i]);
    for (int j = 0; j < DS; j++) d_ofs[j*OFS_W +: OFS_W] = OFS_W'(dof[j]);
    nv = 0; k = 0;
    for (int i = 0; i < CK; i++) begin
      nv += int'(cv[i]);
      use_e[i] = cv[i] && (k < 2);
      if (use_e[i]) k++;
    end
    e.tag = tag; e.ovf = (nv > 2); e.vld = 1'b0; e.ofs = 0;
    e.st  = r ? 1'b0 : mq;
    if (r) begin
      mq = 1'b0;
    end else begin
      q = mq; clv = cs; dl = ds;
      for (int s = 0; s < NS; s++) begin
        for (int i = 0; i < CK; i++) begin
          if (use_e[i] && co[i] == s) begin
            if (!clv) begin
              if (dl != q && !e.vld) begin e.vld = 1'b1; e.ofs = s; end
              q = dl;
            end
            clv = ~clv;
          end
        end
        for (int j = 0; j < DS; j++) if (dv[j] && dof[j] == s) dl = ~dl;
      end
      mq = q;
    end
    sb.push_back(e);
  endtask

  // Monitor: compare at the falling edge of the cycle the bundle was applied in
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (q_start !== e.st || q_vld !== e.vld || int'(q_ofs) != e.ofs || ck_overflow !== e.ovf) begin
          errors++;
          $display("FAIL %s: got st=%0b vld=%0b ofs=%0d ovf=%0b, expected st=%0b vld=%0b ofs=%0d ovf=%0b",
                   e.tag, q_start, q_vld, q_ofs, ck_overflow, e.st, e.vld, e.ofs, e.ovf);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL R1 watchdog: got no completion, expected end of stimulus");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ckl;
    bit dlv;
    ckl = 1'b0; dlv = 1'b0;
    // R7: reset cycle with a rising clock offered
    drive(1, 0, 4'b0001, '{5, 0, 0, 0}, 1, 4'b0000, '{0, 0, 0, 0}, "R7 reset quiet");
    // R2: data falls at the clock offset, old level 1 captured (late rule)
    drive(0, 0, 4'b0001, '{4, 0, 0, 0}, 1, 4'b0001, '{4, 0, 0, 0}, "R2 late data");
    // R5: fall then rise, data dips between
    drive(0, 1, 4'b0011, '{2, 9, 0, 0}, 1, 4'b0011, '{3, 9, 0, 0}, "R5 fall then rise");
    // R4: falling only, level held
    drive(0, 1, 4'b0001, '{1, 0, 0, 0}, 1, 4'b0000, '{0, 0, 0, 0}, "R4 hold no rise");
    // R6: third transition ignored, overflow raised
    drive(0, 0, 4'b0111, '{2, 5, 8, 0}, 1, 4'b0001, '{6, 0, 0, 0}, "R6 overflow");
    // R5: invalid slot ignored
    drive(0, 0, 4'b0010, '{0, 7, 0, 0}, 0, 4'b0000, '{0, 0, 0, 0}, "R5 invalid slot");
    // R2: top offset, data edges before it
    drive(0, 1, 4'b0011, '{0, 15, 0, 0}, 0, 4'b0011, '{14, 3, 0, 0}, "R2 max offset");
    // R4 R3: quiet cycle keeps level
    drive(0, 0, 4'b0000, '{3, 3, 3, 3}, 0, 4'b1111, '{1, 2, 3, 4}, "R3 R4 no clock");
    // R1 R2: same-cycle capture of data that rose earlier
    drive(0, 0, 4'b0001, '{10, 0, 0, 0}, 0, 4'b0001, '{0, 0, 0, 0}, "R1 R2 same cycle");
    // R8: random stimulus against slot-stepping model
    for (int n = 0; n < 3000; n++) begin
      int co[CK];
      int dof[DS];
      bit [CK-1:0] cv;
      bit [DS-1:0] dv;
      int nck;
      int cnt;
      bit r;
      nck = ($urandom_range(0, 9) == 0) ? $urandom_range(3, 4) : $urandom_range(0, 2);
      cnt = 0; cv = '0;
      for (int i = 0; i < CK; i++) co[i] = $urandom_range(0, NS - 1);
      for (int s = 0; s < NS; s++) begin
        if (cnt < nck && $urandom_range(0, NS - 1 - s) < (nck - cnt)) begin
          co[cnt] = s; cv[cnt] = 1'b1; cnt++;
        end
      end
      for (int j = 0; j < DS; j++) begin
        dof[j] = $urandom_range(0, NS - 1);
        dv[j]  = $urandom_range(0, 1);
      end
      r = ($urandom_range(0, 63) == 0);
      drive(r, ckl, cv, co, dlv, dv, dof, "R8 random");
      ckl = ckl ^ cnt[0];
      dlv = dlv ^ (^dv);
    end
    @(posedge clk);
    #1;
    rst = 1'b0; ck_vld = '0; d_vld = '0;
    repeat (3) @(posedge clk);
    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule